// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from the moment reset is released until the memory is ready for normal traffic. It holds the bus on no-operation commands through a long settling interval. It then closes every bank with a single precharge and runs two auto-refresh cycles. After that it writes the standard mode register and then the extended mode register. The extended register carries the partial-array self-refresh span and the output drive strength. Every command is followed by a gap of the required length, filled with no-operation commands.

All gap lengths are given in nanoseconds and converted to clock cycles using a clock-frequency parameter. The mode-register contents come in as separate field ports: burst length, burst order, CAS latency, operating mode, write-burst mode, refresh span and drive strength. The block packs these fields into address-bus words. When the last gap has expired, `init_done` rises and stays high, and a normal controller can then take over the pins. Reset is synchronous and active high. Asserting reset at any point restarts the whole script.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, every command is NOP (CS#,RAS#,CAS#,WE# = L,H,H,H) until the PRECHARGE appears on the pins following the PWRUP-th rising edge, where PWRUP = ceil(T_PWRUP_NS * CLK_MHZ / 1000) (25000 at the defaults).
- R2: CKE is low while reset is held, is high from the first rising edge after release, and never drops again before the next reset.
- R3: Exactly one PRECHARGE (L,L,H,L) is issued, with address bit 10 high, all other address bits low and bank address 00.
- R4: Two AUTO REFRESH commands (L,L,L,H) follow with address and bank address all zero. The first comes RP cycles after the precharge and the second comes RFC cycles after the first, where RP = ceil(20 ns * CLK_MHZ/1000) = 5 and RFC = ceil(70 ns * CLK_MHZ/1000) = 18.
- R5: The standard mode load (L,L,L,L, bank address 00) comes RFC cycles after the second refresh. Its address bits are: bits 2:0 burst length, bit 3 burst order, bits 6:4 CAS latency, bits 8:7 operating mode, bit 9 write-burst mode.
- R6: Address bits 11:10 are zero on the standard mode load.
- R7: The extended mode load (L,L,L,L, bank address 10) comes MRD cycles (default 2) after the standard load. Its address bits are: bits 2:0 refresh span, bits 6:5 drive strength, and all other bits zero.
- R8: `init_done` is low until the MRD-th edge after the extended load. From that edge onward it stays high, with the pins held on NOP and CKE high.
- R9: A reset asserted in the middle of the script returns the pins to NOP with CKE low and `init_done` low, and the whole script restarts with the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_len | input | 3 | Burst-length code for the standard register |
| burst_interleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cas_lat | input | 3 | CAS latency code |
| op_mode | input | 2 | Operating-mode code |
| wr_single | input | 1 | Write-burst mode bit |
| refresh_span | input | 3 | Partial-array self-refresh span code |
| drive_sel | input | 2 | Output drive strength code |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| init_done | output | 1 | High once the memory is ready |

## Verification
The hardest case to reach from the ports is a reset that lands inside a gap late in the script, after the power-up wait has already been served. At that point the sequencer must drop everything and serve the full wait again. The stimulus runs a sequence, watches the pins until the second refresh has gone out, and asserts reset while the refresh gap is still counting. The next run is then checked cycle by cycle from a clean start. The other runs use a directed pattern with every field bit set and seeded random field values, so that each bit position of both register words is seen.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        STP_POWERUP,
        STP_AFTER_PRE,
        STP_AFTER_REF1,
        STP_AFTER_REF2,
        STP_AFTER_MRS,
        STP_AFTER_EMRS,
        STP_READY
    } step_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_REFRESH,
        CMD_LOAD_MODE
    } cmd_e;

    // Round a duration up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int dur_ns, input int clk_mhz);
        int c;
        c = (dur_ns * clk_mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdram_init_words.sv
module sdram_init_words
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_interleave,
    input  logic [2:0]        cas_lat,
    input  logic [1:0]        op_mode,
    input  logic              wr_single,
    input  logic [2:0]        refresh_span,
    input  logic [1:0]        drive_sel,
    output logic [ADDR_W-1:0] std_word,
    output logic [ADDR_W-1:0] ext_word
);
    // Field positions are decoded by the memory itself, so they are fixed.
    localparam int STD_USED = 10;
    localparam int EXT_USED = 7;

    logic [STD_USED-1:0] std_low;
    logic [EXT_USED-1:0] ext_low;

    always_comb begin
        std_low = {wr_single, op_mode, cas_lat, burst_interleave, burst_len};
        ext_low = {drive_sel, 2'b00, refresh_span};
    end

    // Every bit above the used fields is forced to zero.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bits
        if (b < STD_USED) begin : g_std
            assign std_word[b] = std_low[b];
        end else begin : g_std_zero
            assign std_word[b] = 1'b0;
        end
        if (b < EXT_USED) begin : g_ext
            assign ext_word[b] = ext_low[b];
        end else begin : g_ext_zero
            assign ext_word[b] = 1'b0;
        end
    end

endmodule

// File: rtl/sdram_init_script.sv
module sdram_init_script
    import sdram_init_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int RP_CYC  = 5,
    parameter int RFC_CYC = 18,
    parameter int MRD_CYC = 2
) (
    input  step_e             step,
    output step_e             next_step,
    output cmd_e              next_cmd,
    output logic              next_ext,
    output logic [CNT_W-1:0]  next_reload
);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(RP_CYC - 1);
    localparam logic [CNT_W-1:0] RFC_LOAD = CNT_W'(RFC_CYC - 1);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(MRD_CYC - 1);

    // One row per script step: what to issue when its gap runs out.
    always_comb begin
        next_step   = STP_READY;
        next_cmd    = CMD_NOP;
        next_ext    = 1'b0;
        next_reload = '0;
        unique case (step)
            STP_POWERUP: begin
                next_step   = STP_AFTER_PRE;
                next_cmd    = CMD_PRECHARGE;
                next_reload = RP_LOAD;
            end
            STP_AFTER_PRE: begin
                next_step   = STP_AFTER_REF1;
                next_cmd    = CMD_REFRESH;
                next_reload = RFC_LOAD;
            end
            STP_AFTER_REF1: begin
                next_step   = STP_AFTER_REF2;
                next_cmd    = CMD_REFRESH;
                next_reload = RFC_LOAD;
            end
            STP_AFTER_REF2: begin
                next_step   = STP_AFTER_MRS;
                next_cmd    = CMD_LOAD_MODE;
                next_reload = MRD_LOAD;
            end
            STP_AFTER_MRS: begin
                next_step   = STP_AFTER_EMRS;
                next_cmd    = CMD_LOAD_MODE;
                next_ext    = 1'b1;
                next_reload = MRD_LOAD;
            end
            STP_AFTER_EMRS: begin
                next_step   = STP_READY;
            end
            default: begin
                next_step   = STP_READY;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  cmd_e              cmd,
    input  logic              ext_sel,
    input  logic [ADDR_W-1:0] word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int ALL_BANKS_BIT = 10;
    localparam logic [BA_W-1:0] EXT_BANK = BA_W'(2);

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_PRECHARGE: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                addr[ALL_BANKS_BIT] = 1'b1;
            end
            CMD_REFRESH: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_LOAD_MODE: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = ext_sel ? EXT_BANK : '0;
                addr  = word;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter int T_PWRUP_NS  = 100000,
    parameter int T_RP_NS     = 20,
    parameter int T_RFC_NS    = 70,
    parameter int T_MRD_CYC   = 2,
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        burst_len,
    input  logic              burst_interleave,
    input  logic [2:0]        cas_lat,
    input  logic [1:0]        op_mode,
    input  logic              wr_single,
    input  logic [2:0]        refresh_span,
    input  logic [1:0]        drive_sel,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);
    localparam int PW_CYC  = ns_to_cycles(T_PWRUP_NS, CLK_MHZ);
    localparam int RP_CYC  = ns_to_cycles(T_RP_NS, CLK_MHZ);
    localparam int RFC_CYC = ns_to_cycles(T_RFC_NS, CLK_MHZ);
    localparam int MRD_CYC = (T_MRD_CYC < 1) ? 1 : T_MRD_CYC;
    localparam int MAX_A   = (PW_CYC > RFC_CYC) ? PW_CYC : RFC_CYC;
    localparam int MAX_B   = (RP_CYC > MRD_CYC) ? RP_CYC : MRD_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PW_LOAD = CNT_W'(PW_CYC - 1);

    typedef struct packed {
        step_e              step;
        logic [CNT_W-1:0]   cnt;
        cmd_e               cmd;
        logic               ext;
        logic [ADDR_W-1:0]  word;
        logic               cke;
        logic               done;
    } seq_t;

    seq_t s_d, s_q;

    logic [ADDR_W-1:0] std_word, ext_word;
    step_e             nx_step;
    cmd_e              nx_cmd;
    logic              nx_ext;
    logic [CNT_W-1:0]  nx_reload;

    sdram_init_words #(.ADDR_W(ADDR_W)) u_words (
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .cas_lat          (cas_lat),
        .op_mode          (op_mode),
        .wr_single        (wr_single),
        .refresh_span     (refresh_span),
        .drive_sel        (drive_sel),
        .std_word         (std_word),
        .ext_word         (ext_word)
    );

    sdram_init_script #(
        .CNT_W   (CNT_W),
        .RP_CYC  (RP_CYC),
        .RFC_CYC (RFC_CYC),
        .MRD_CYC (MRD_CYC)
    ) u_script (
        .step        (s_q.step),
        .next_step   (nx_step),
        .next_cmd    (nx_cmd),
        .next_ext    (nx_ext),
        .next_reload (nx_reload)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.ext  = 1'b0;
        s_d.word = '0;
        s_d.cke  = 1'b1;
        if (s_q.step != STP_READY) begin
            if (s_q.cnt == '0) begin
                s_d.step = nx_step;
                s_d.cnt  = nx_reload;
                s_d.cmd  = nx_cmd;
                s_d.ext  = nx_ext;
                s_d.word = nx_ext ? ext_word : std_word;
                s_d.done = (nx_step == STP_READY);
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.step <= STP_POWERUP;
            s_q.cnt  <= PW_LOAD;
            s_q.cmd  <= CMD_NOP;
            s_q.ext  <= 1'b0;
            s_q.word <= '0;
            s_q.cke  <= 1'b0;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    sdram_init_pins #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .cmd     (s_q.cmd),
        .ext_sel (s_q.ext),
        .word    (s_q.word),
        .cs_n    (sd_cs_n),
        .ras_n   (sd_ras_n),
        .cas_n   (sd_cas_n),
        .we_n    (sd_we_n),
        .ba      (sd_ba),
        .addr    (sd_addr)
    );

    assign sd_cke    = s_q.cke;
    assign init_done = s_q.done;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int PW     = 25000,
    parameter int RP     = 5,
    parameter int RFC    = 18,
    parameter int MRD    = 2,
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_LMR = 4'b0000;

    logic [3:0]  pins;
    logic        is_cmd;
    logic [2:0]  idx_q;
    logic [31:0] gap_q;
    logic        live_q;
    logic [31:0] want_gap;
    logic [3:0]  want_pins;

    assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_cmd = (pins != P_NOP);

    always_comb begin
        unique case (idx_q)
            3'd0:    begin want_gap = PW;  want_pins = P_PRE; end
            3'd1:    begin want_gap = RP;  want_pins = P_REF; end
            3'd2:    begin want_gap = RFC; want_pins = P_REF; end
            3'd3:    begin want_gap = RFC; want_pins = P_LMR; end
            3'd4:    begin want_gap = MRD; want_pins = P_LMR; end
            default: begin want_gap = 0;   want_pins = P_NOP; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            gap_q  <= '0;
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (is_cmd) begin
                idx_q <= idx_q + 3'd1;
                gap_q <= 32'd1;
            end else if (gap_q != 32'hFFFF_FFFF) begin
                gap_q <= gap_q + 32'd1;
            end
        end
    end

    // R1 R4 R5 R7: each command lands exactly its gap after the previous one
    a_r1_gap_exact: assert property (@(posedge clk) disable iff (rst)
        is_cmd |-> (gap_q == want_gap));

    // R3 R4 R5: commands appear in script order, and no more than five
    a_r3_order: assert property (@(posedge clk) disable iff (rst)
        is_cmd |-> (idx_q < 3'd5 && pins == want_pins));

    a_r3_all_banks: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && idx_q == 3'd0) |-> (sd_addr[10] && sd_ba == '0));

    a_r6_std_reserved: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && idx_q == 3'd3) |-> (sd_ba == '0 && sd_addr[11:10] == 2'b00));

    a_r7_ext_select: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && idx_q == 3'd4) |-> (sd_ba == BA_W'(2) && sd_addr[11:7] == 5'd0));

    a_r2_cke_high: assert property (@(posedge clk) disable iff (rst)
        live_q |-> sd_cke);

    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && !is_cmd));

    a_r8_done_after_all: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (idx_q == 3'd5 && gap_q == MRD));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .PW     (PW_CYC),
    .RP     (RP_CYC),
    .RFC    (RFC_CYC),
    .MRD    (MRD_CYC),
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .init_done (init_done)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

    localparam int MHZ     = 250;
    localparam int PW      = (100000 * MHZ + 999) / 1000;
    localparam int RP      = (20 * MHZ + 999) / 1000;
    localparam int RFC     = (70 * MHZ + 999) / 1000;
    localparam int MRD     = 2;
    localparam int K_PRE   = PW;
    localparam int K_REF1  = K_PRE + RP;
    localparam int K_REF2  = K_REF1 + RFC;
    localparam int K_LMR   = K_REF2 + RFC;
    localparam int K_EMR   = K_LMR + MRD;
    localparam int K_DONE  = K_EMR + MRD;

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  burst_len = '0;
    logic        burst_interleave = 1'b0;
    logic [2:0]  cas_lat = '0;
    logic [1:0]  op_mode = '0;
    logic        wr_single = 1'b0;
    logic [2:0]  refresh_span = '0;
    logic [1:0]  drive_sel = '0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    sdram_init_seq uut (
        .clk(clk), .rst(rst),
        .burst_len(burst_len), .burst_interleave(burst_interleave),
        .cas_lat(cas_lat), .op_mode(op_mode), .wr_single(wr_single),
        .refresh_span(refresh_span), .drive_sel(drive_sel),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .init_done(init_done)
    );

    function automatic logic [11:0] std_val(input logic [2:0] bl, input logic bt,
                                            input logic [2:0] cl, input logic [1:0] om,
                                            input logic wb);
        logic [11:0] w;
        w = '0;
        w[2:0] = bl; w[3] = bt; w[6:4] = cl; w[8:7] = om; w[9] = wb;
        return w;
    endfunction

    function automatic logic [11:0] ext_val(input logic [2:0] sp, input logic [1:0] ds);
        logic [11:0] w;
        w = '0;
        w[2:0] = sp; w[6:5] = ds;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int bus();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
    endfunction

    task automatic run_seq(input int abort_at, input string rst_req);
        int nop_bad = 0, cke_bad = 0, done_bad = 0;
        int nop_act = 0, nop_exp = 0;
        logic [11:0] sw, ew;
        int exp_bus;
        string req;
        sw = std_val(burst_len, burst_interleave, cas_lat, op_mode, wr_single);
        ew = ext_val(refresh_span, drive_sel);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(sd_cke == 1'b0 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP
              && init_done == 1'b0, rst_req, "pins during reset",
              {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done},
              {1'b0, P_NOP, 1'b0});
        rst = 1'b0;
        for (int k = 1; k <= K_DONE + 20; k++) begin
            @(negedge clk);
            if (abort_at > 0 && k == abort_at) return;
            if (sd_cke !== 1'b1) cke_bad++;
            if (init_done !== (k >= K_DONE)) done_bad++;
            exp_bus = -1;
            req = "";
            if (k == K_PRE)  begin exp_bus = {P_PRE, 2'b00, 12'h400}; req = "R3"; end
            if (k == K_REF1) begin exp_bus = {P_REF, 2'b00, 12'h000}; req = "R4"; end
            if (k == K_REF2) begin exp_bus = {P_REF, 2'b00, 12'h000}; req = "R4"; end
            if (k == K_LMR)  begin exp_bus = {P_LMR, 2'b00, sw};      req = "R5 R6"; end
            if (k == K_EMR)  begin exp_bus = {P_LMR, 2'b10, ew};      req = "R7"; end
            if (exp_bus >= 0) begin
                check(bus() == exp_bus, req, "command word at its cycle", bus(), exp_bus);
            end else if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != P_NOP) begin
                if (nop_bad == 0) begin
                    nop_act = k;
                    nop_exp = bus();
                end
                nop_bad++;
            end
        end
        // R1: only NOP on the bus outside the scripted cycles
        check(nop_bad == 0, "R1", "stray command (cycle, bus)", nop_act, nop_exp);
        check(cke_bad == 0, "R2", "cycles with CKE low after release", cke_bad, 0);
        check(done_bad == 0, "R8", "cycles with wrong init_done", done_bad, 0);
    endtask

    task automatic set_fields(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                              input logic [1:0] om, input logic wb,
                              input logic [2:0] sp, input logic [1:0] ds);
        burst_len = bl; burst_interleave = bt; cas_lat = cl; op_mode = om;
        wr_single = wb; refresh_span = sp; drive_sel = ds;
    endtask

    initial begin
        #(4 * 200000);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] bl_pick [5];
        int seed;
        bl_pick = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
        seed = $urandom(32'd4242);
        // directed: every field bit set, checks all R5/R7 positions
        set_fields(3'd7, 1'b1, 3'd7, 2'b11, 1'b1, 3'd7, 2'b11);
        run_seq(0, "R2");
        // directed corner: reset during the second refresh gap
        set_fields(3'd3, 1'b0, 3'd2, 2'b00, 1'b0, 3'd1, 2'b01);
        run_seq(K_REF2 + 3, "R2");
        // R9: full restart after the mid-script reset
        run_seq(0, "R9");
        // seeded random field values
        for (int r = 0; r < 1; r++) begin
            set_fields(bl_pick[$urandom % 5], 1'($urandom), 3'($urandom % 2 + 2),
                       2'($urandom), 1'($urandom), 3'($urandom), 2'($urandom));
            run_seq(0, "R2");
        end
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule